// File: doc/BRIEF.md
# Floppy Controller Data Rate and Power Control Register

This block is the write-only rate and power control register of a floppy disk controller's host interface. A host write at register offset 4 stores a 2-bit data rate code and a 3-bit write precompensation code. The same byte can also request manual low power or a software reset of the controller core. A second register at offset 7, the configuration control register, also carries a rate code. The rate the block drives out comes from whichever of the two registers the host wrote last.

The block turns the software reset bit into a fixed-length core reset pulse that clears itself, and it also passes on the reset request from the digital output register. It holds a low-power level that the clock and data-separator logic use to gate themselves off. Low power ends when the core is reset, or when the host reads the main status port (a read at offset 4) or accesses the data port (offset 5). A software reset from either source never changes the stored rate or precompensation fields.

Top module: `fdc_rate_ctl`

## Requirements
- R1: After hardware reset, eff_rate is 2'b10 (250 Kbps), precomp is 3'b000, low_power is 0 and core_reset is 0.
- R2: A host write at offset 4 loads host_wdata[1:0] as the rate code and host_wdata[4:2] as the precompensation code. Both outputs show the new values in the cycle after the write edge. The value of host_wdata[5] has no effect on any output.
- R3: precomp changes only on a write at offset 4. A software reset, whether from bit 7 or from dor_reset, leaves the stored rate and precompensation values unchanged.
- R4: eff_rate equals host_wdata[1:0] of the most recent write at offset 4 or offset 7. Writes at any other offset, and all reads, leave eff_rate unchanged.
- R5: A write at offset 4 with host_wdata[7]=1 drives core_reset high for exactly 4 cycles, starting the cycle after the write edge, and then releases it. A new such write during the pulse restarts the 4-cycle count.
- R6: A write at offset 4 with host_wdata[6]=1 and host_wdata[7]=0 sets low_power in the next cycle.
- R7: low_power clears in the cycle after a read at offset 4 or a read or write at offset 5. A read at offset 4 does not change eff_rate or precomp. Accesses at offsets 0 to 3, 6 and 7 leave low_power set.
- R8: core_reset is high in every cycle that follows a cycle with dor_reset high. dor_reset high clears low_power.
- R9: A write at offset 4 with both host_wdata[7] and host_wdata[6] set starts the reset pulse and leaves low_power at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_addr | input | 3 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| dor_reset | input | 1 | Reset request from the digital output register |
| eff_rate | output | 2 | Effective data rate code |
| precomp | output | 3 | Write precompensation code |
| low_power | output | 1 | Manual low-power enable for clock and data separator |
| core_reset | output | 1 | Reset to the controller core |

## Verification
The assertions assume that host_wr and host_rd are never high together and that each strobe marks one complete access. Under that assumption, every strobe cycle is exactly one decoded event at one offset. They also assume dor_reset is low whenever the entry into low power is checked. The bench drives each access as a one-cycle strobe that starts on a falling edge and never raises both strobes together. It holds dor_reset low except inside the scenario that tests it.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

  // Bit positions inside the rate/power control byte.
  localparam int unsigned RATE_LSB   = 0;
  localparam int unsigned PCOMP_LSB  = 2;
  localparam int unsigned RSVD_BIT   = 5;
  localparam int unsigned LPWR_BIT   = 6;
  localparam int unsigned SWRST_BIT  = 7;

  // Which register supplied the effective rate most recently.
  typedef enum logic {
    SRC_RATE_REG = 1'b0,
    SRC_CFG_REG  = 1'b1
  } rate_src_e;

endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned RATE_OFS = 4,
  parameter int unsigned DATA_OFS = 5,
  parameter int unsigned CFG_OFS  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              rate_wr,
  output logic              cfg_wr,
  output logic              wake
);

  localparam logic [ADDR_W-1:0] RATE_A = ADDR_W'(RATE_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);

  logic hit_rate;
  logic hit_data;
  logic hit_cfg;

  always_comb begin
    hit_rate = (addr == RATE_A);
    hit_data = (addr == DATA_A);
    hit_cfg  = (addr == CFG_A);
    rate_wr  = wr & hit_rate;
    cfg_wr   = wr & hit_cfg;
    // A read at the rate offset is a status read; the data port wakes on any access.
    wake     = (rd & hit_rate) | ((rd | wr) & hit_data);
  end

endmodule

// File: rtl/fdc_rate_arb.sv
module fdc_rate_arb
  import fdc_rate_pkg::*;
#(
  parameter int unsigned      RATE_W   = 2,
  parameter logic [RATE_W-1:0] RST_RATE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic              cfg_wr,
  input  logic [RATE_W-1:0] wr_rate,
  output logic [RATE_W-1:0] eff_rate
);

  logic [RATE_W-1:0] own_rate_q, own_rate_d;
  logic [RATE_W-1:0] cfg_rate_q, cfg_rate_d;
  rate_src_e         src_q, src_d;

  always_comb begin
    own_rate_d = own_rate_q;
    cfg_rate_d = cfg_rate_q;
    src_d      = src_q;
    if (rate_wr) begin
      own_rate_d = wr_rate;
      src_d      = SRC_RATE_REG;
    end else if (cfg_wr) begin
      cfg_rate_d = wr_rate;
      src_d      = SRC_CFG_REG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_rate_q <= RST_RATE;
      cfg_rate_q <= RST_RATE;
      src_q      <= SRC_RATE_REG;
    end else begin
      if (rate_wr) own_rate_q <= own_rate_d;
      if (cfg_wr)  cfg_rate_q <= cfg_rate_d;
      if (rate_wr | cfg_wr) src_q <= src_d;
    end
  end

  assign eff_rate = (src_q == SRC_CFG_REG) ? cfg_rate_q : own_rate_q;

endmodule

// File: rtl/fdc_swrst_pulse.sv
module fdc_swrst_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ext_rst,
  output logic core_reset
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;

  always_comb begin
    if (start)
      cnt_d = CNT_LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
    rst_d = (cnt_d != '0) | ext_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign core_reset = rst_q;

endmodule

// File: rtl/fdc_power_ctl.sv
module fdc_power_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic low_power
);

  logic lp_q, lp_d;

  always_comb begin
    lp_d = lp_q;
    if (leave)
      lp_d = 1'b0;
    else if (enter)
      lp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp_d;
  end

  assign low_power = lp_q;

endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl
  import fdc_rate_pkg::*;
#(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RATE_W       = 2,
  parameter int unsigned PCOMP_W      = 3,
  parameter int unsigned PULSE_CYCLES = 4,
  parameter int unsigned RATE_OFS     = 4,
  parameter int unsigned DATA_OFS     = 5,
  parameter int unsigned CFG_OFS      = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               dor_reset,
  output logic [RATE_W-1:0]  eff_rate,
  output logic [PCOMP_W-1:0] precomp,
  output logic               low_power,
  output logic               core_reset
);

  localparam logic [RATE_W-1:0]  RST_RATE  = RATE_W'(2);
  localparam logic [PCOMP_W-1:0] RST_PCOMP = '0;
  localparam logic [DATA_W-1:0]  RSVD_MASK = ~(DATA_W'(1) << RSVD_BIT);

  logic               rate_wr, cfg_wr, wake;
  logic [DATA_W-1:0]  wbyte;
  logic               sw_start, lp_enter, lp_leave;
  logic [PCOMP_W-1:0] pcomp_q, pcomp_d;

  fdc_host_decode #(
    .ADDR_W  (ADDR_W),
    .RATE_OFS(RATE_OFS),
    .DATA_OFS(DATA_OFS),
    .CFG_OFS (CFG_OFS)
  ) i_decode (
    .addr   (host_addr),
    .wr     (host_wr),
    .rd     (host_rd),
    .rate_wr(rate_wr),
    .cfg_wr (cfg_wr),
    .wake   (wake)
  );

  // Reserved bit is forced to zero before anything is stored.
  always_comb begin
    wbyte    = host_wdata & RSVD_MASK;
    sw_start = rate_wr & wbyte[SWRST_BIT];
    lp_enter = rate_wr & wbyte[LPWR_BIT] & ~wbyte[SWRST_BIT];
    lp_leave = wake | sw_start | dor_reset;
    pcomp_d  = rate_wr ? wbyte[PCOMP_LSB +: PCOMP_W] : pcomp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcomp_q <= RST_PCOMP;
    else if (rate_wr) pcomp_q <= pcomp_d;
  end

  assign precomp = pcomp_q;

  fdc_rate_arb #(
    .RATE_W  (RATE_W),
    .RST_RATE(RST_RATE)
  ) i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_wr (rate_wr),
    .cfg_wr  (cfg_wr),
    .wr_rate (wbyte[RATE_LSB +: RATE_W]),
    .eff_rate(eff_rate)
  );

  fdc_swrst_pulse #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) i_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sw_start),
    .ext_rst   (dor_reset),
    .core_reset(core_reset)
  );

  fdc_power_ctl i_power (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (lp_enter),
    .leave    (lp_leave),
    .low_power(low_power)
  );

endmodule

// File: rtl/fdc_rate_ctl_chk.sv
module fdc_rate_ctl_chk #(
  parameter int unsigned ADDR_W       = 3,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RATE_W       = 2,
  parameter int unsigned PCOMP_W      = 3,
  parameter int unsigned PULSE_CYCLES = 4,
  parameter int unsigned RATE_OFS     = 4,
  parameter int unsigned DATA_OFS     = 5,
  parameter int unsigned CFG_OFS      = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  host_addr,
  input logic               host_wr,
  input logic               host_rd,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               dor_reset,
  input logic [RATE_W-1:0]  eff_rate,
  input logic [PCOMP_W-1:0] precomp,
  input logic               low_power,
  input logic               core_reset
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(PULSE_CYCLES);

  logic ev_rate_wr, ev_cfg_wr, ev_wake, ev_sw;
  assign ev_rate_wr = host_wr && (host_addr == ADDR_W'(RATE_OFS));
  assign ev_cfg_wr  = host_wr && (host_addr == ADDR_W'(CFG_OFS));
  assign ev_wake    = (host_rd && (host_addr == ADDR_W'(RATE_OFS))) ||
                      ((host_rd || host_wr) && (host_addr == ADDR_W'(DATA_OFS)));
  assign ev_sw      = ev_rate_wr && host_wdata[7];

  // Cycles since the last software reset write, saturating at the pulse length.
  logic [CNT_W-1:0] since_q;
  logic             dor_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SAT;
      dor_q   <= 1'b0;
    end else begin
      dor_q <= dor_reset;
      if (ev_sw)              since_q <= '0;
      else if (since_q < SAT) since_q <= since_q + 1'b1;
    end
  end

  assert_swrst_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sw |=> core_reset);

  assert_swrst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reset && !dor_q) |-> (since_q < SAT));

  assert_dor_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dor_reset |=> (core_reset && !low_power));

  assert_rate_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rate_wr |=> (eff_rate == $past(host_wdata[RATE_W-1:0])));

  assert_rate_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_wr |=> (eff_rate == $past(host_wdata[RATE_W-1:0])));

  assert_rate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rate_wr && !ev_cfg_wr) |=> $stable(eff_rate));

  assert_pcomp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rate_wr |=> $stable(precomp));

  assert_lp_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rate_wr && host_wdata[6] && !host_wdata[7] && !dor_reset) |=> low_power);

  assert_lp_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> !low_power);

  assert_both_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sw |=> !low_power);

endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .RATE_W      (RATE_W),
  .PCOMP_W     (PCOMP_W),
  .PULSE_CYCLES(PULSE_CYCLES),
  .RATE_OFS    (RATE_OFS),
  .DATA_OFS    (DATA_OFS),
  .CFG_OFS     (CFG_OFS)
) i_fdc_rate_ctl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_wdata(host_wdata),
  .dor_reset (dor_reset),
  .eff_rate  (eff_rate),
  .precomp   (precomp),
  .low_power (low_power),
  .core_reset(core_reset)
);

// File: tb/test_fdc_rate_ctl.sv
module test_fdc_rate_ctl;

  logic       clk;
  logic       rst_n;
  logic [2:0] host_addr;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_wdata;
  logic       dor_reset;
  logic [1:0] eff_rate;
  logic [2:0] precomp;
  logic       low_power;
  logic       core_reset;

  int n_checks = 0;
  int n_fail   = 0;

  fdc_rate_ctl i_fdc_rate_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .dor_reset (dor_reset),
    .eff_rate  (eff_rate),
    .precomp   (precomp),
    .low_power (low_power),
    .core_reset(core_reset)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge; one-cycle strobes.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = 8'h00;
  endtask

  task automatic rd(input logic [2:0] a);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulse(input string req, input int exp);
    int highs = 0;
    for (int i = 0; i < 10; i++) begin
      if (core_reset) highs++;
      @(negedge clk);
    end
    check(req, "core_reset pulse length", highs, exp);
  endtask

  task automatic t_reset;
    check("R1", "eff_rate after reset", eff_rate, 2);
    check("R1", "precomp after reset", precomp, 0);
    check("R1", "low_power after reset", low_power, 0);
    check("R1", "core_reset after reset", core_reset, 0);
  endtask

  task automatic t_fields;
    wr(3'd4, 8'b000_101_01);
    check("R2", "rate field", eff_rate, 1);
    check("R2", "precomp field", precomp, 5);
    wr(3'd4, 8'b001_011_11);   // bit5 set must be ignored
    check("R2", "rate with reserved bit", eff_rate, 3);
    check("R2", "precomp with reserved bit", precomp, 3);
    check("R2", "reserved bit no low power", low_power, 0);
    check("R2", "reserved bit no reset", core_reset, 0);
  endtask

  task automatic t_arbitration;
    wr(3'd4, 8'b000_010_00);
    check("R4", "rate after own write", eff_rate, 0);
    wr(3'd7, 8'h02);
    check("R4", "rate after cfg write", eff_rate, 2);
    check("R3", "precomp untouched by cfg write", precomp, 2);
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h01);
    rd(3'd7);
    check("R4", "rate unchanged by other offsets", eff_rate, 2);
    wr(3'd4, 8'b000_010_01);
    check("R4", "own write wins again", eff_rate, 1);
    wr(3'd7, 8'h03);
    check("R4", "cfg write wins again", eff_rate, 3);
  endtask

  task automatic t_pulse;
    wr(3'd4, 8'b1000_1101);
    check("R5", "core_reset starts", core_reset, 1);
    check("R3", "fields of reset write stored (rate)", eff_rate, 1);
    check("R3", "fields of reset write stored (pcomp)", precomp, 3);
    count_pulse("R5", 4);
    check("R3", "rate kept after reset", eff_rate, 1);
    check("R3", "precomp kept after reset", precomp, 3);
  endtask

  task automatic t_restart;
    wr(3'd4, 8'b1000_1101);
    idle(2);
    check("R5", "pulse still high before restart", core_reset, 1);
    wr(3'd4, 8'b1000_1101);
    count_pulse("R5", 4);
  endtask

  task automatic t_low_power;
    wr(3'd4, 8'b0100_1101);
    check("R6", "low power entered", low_power, 1);
    wr(3'd6, 8'h00);
    rd(3'd3);
    wr(3'd7, 8'h01);
    check("R7", "low power kept by other offsets", low_power, 1);
    rd(3'd4);
    check("R7", "status read wakes", low_power, 0);
    check("R7", "status read keeps precomp", precomp, 3);
    check("R7", "status read keeps rate", eff_rate, 1);
    wr(3'd4, 8'b0100_1101);
    rd(3'd5);
    check("R7", "data read wakes", low_power, 0);
    wr(3'd4, 8'b0100_1101);
    wr(3'd5, 8'h55);
    check("R7", "data write wakes", low_power, 0);
    wr(3'd4, 8'b0100_1101);
    wr(3'd4, 8'b1000_1101);
    check("R7", "software reset wakes", low_power, 0);
    idle(6);
  endtask

  task automatic t_dor;
    wr(3'd4, 8'b0101_0110);
    check("R6", "low power before dor", low_power, 1);
    dor_reset = 1'b1;
    @(negedge clk);
    check("R8", "core_reset follows dor", core_reset, 1);
    check("R8", "dor clears low power", low_power, 0);
    @(negedge clk);
    check("R8", "core_reset held with dor", core_reset, 1);
    dor_reset = 1'b0;
    @(negedge clk);
    check("R8", "core_reset released after dor", core_reset, 0);
    check("R3", "dor keeps rate", eff_rate, 2);
    check("R3", "dor keeps precomp", precomp, 5);
  endtask

  task automatic t_both;
    wr(3'd4, 8'b1100_0000);
    check("R9", "reset wins over low power", low_power, 0);
    check("R9", "reset pulse started", core_reset, 1);
    count_pulse("R9", 4);
    check("R9", "still not in low power", low_power, 0);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; dor_reset = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fields();
        t_arbitration();
        t_pulse();
        t_restart();
        t_low_power();
        t_dor();
        t_both();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule